// File: doc/BRIEF.md
# Packed Subword SIMD ALU

This execution unit treats each of its two 64-bit source operands as a packed vector of equal-width lanes and applies one operation to every lane at once. The lane width can be 8, 16, 32 or 64 bits and is chosen per operation. The unit covers the following operations:

- add and subtract, in either wrapping or clamping form;
- 16-bit lane products, keeping the low half or the high half of each product;
- a multiply-add that sums neighbouring products into 32-bit results;
- lane comparisons that produce all-ones or all-zeros masks;
- shifts confined to each lane;
- plain bitwise logic across the whole word.

No carry, borrow or shifted bit crosses a lane boundary.

The unit sits in an execute stage. Decoded control and two source values arrive on one clock edge, and the result is registered on that edge. A new operation can be issued every cycle. Register file access, memory access and instruction decode happen outside the unit.

Top module: `psimd_alu`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it falls, `res_o` is cleared to zero. This holds even if a valid operation is presented at the inputs.
- R2: The result of the operation presented before a rising clock edge appears on `res_o` after that edge and holds until the next edge. One operation can be issued per cycle. `op_i` codes: 0 add, 1 subtract, 2 multiply-low, 3 multiply-high, 4 multiply-add, 5 compare-equal, 6 compare-greater, 7 shift-left, 8 logical shift-right, 9 arithmetic shift-right, 10 AND, 11 AND-NOT (`~a_i & b_i`), 12 OR, 13 XOR.
- R3: `lsz_i` selects the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. When `sat_i` is 0, add and subtract wrap within each lane, and no carry or borrow passes into the adjacent lane.
- R4: With `sat_i`=1 and `sgn_i`=1, a sum or difference that leaves the two's-complement range of its lane is clamped to that lane's minimum or maximum.
- R5: With `sat_i`=1 and `sgn_i`=0, an unsigned sum that overflows clamps to all ones, and an unsigned difference that underflows clamps to zero.
- R6: Compare-equal writes all ones into a lane when the two lanes are equal and zeros otherwise. Compare-greater does the same when the lane of `a_i` is greater than the lane of `b_i` as signed numbers.
- R7: Multiply uses four 16-bit lanes regardless of `lsz_i`. It returns the low 16 bits (code 2) or the high 16 bits (code 3) of each 32-bit product. The operands are treated as signed when `sgn_i`=1 and as unsigned when `sgn_i`=0.
- R8: Multiply-add forms the four 16-bit lane products, with signedness taken from `sgn_i`. Bits 31:0 of the result are product 0 plus product 1, and bits 63:32 are product 2 plus product 3. Each sum is taken modulo 2^32.
- R9: Shifts move the bits of each lane by the unsigned value of the whole of `b_i`. Bits that leave a lane are dropped. Logical shifts fill with zeros, and the arithmetic right shift fills with the lane's sign bit.
- R10: A shift count equal to or greater than the lane width gives a zero lane for logical shifts, and a lane filled with its sign bit for the arithmetic right shift.
- R11: AND, AND-NOT, OR and XOR act on all 64 bits, and `lsz_i`, `sat_i` and `sgn_i` have no effect on them.
- R12: `op_i` codes 14 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| lsz_i | input | 2 | Lane width select |
| sat_i | input | 1 | 1 = clamp add/subtract, 0 = wrap |
| sgn_i | input | 1 | 1 = signed clamping and products |
| a_i | input | 64 | First packed source |
| b_i | input | 64 | Second packed source, or shift count |
| res_o | output | 64 | Registered packed result |

## Verification
While one operation's result is held in the output register, the next operation, often of a different class, is already being evaluated. A stale value or a wrong select at that register would therefore mix the two. The stimulus table is issued one vector per cycle with no idle gaps, and it deliberately alternates lane widths, clamping modes and functional classes. Each result is compared in the cycle after its issue, and a directed test checks that the output does not move before the edge. A reset raised while an XOR with a non-zero result is pending is also checked: the pending result must be replaced by zero.

// File: rtl/pk_pkg.sv
// Shared definitions for the packed SIMD execution unit.
// Assumes a 64-bit datapath with lane widths that are powers of two from 8 bits up.
package pk_pkg;
    localparam int DATA_W      = 64;
    localparam int MIN_LANE_W  = 8;
    localparam int NUM_SIZES   = 4;
    localparam int LSZ_W       = $clog2(NUM_SIZES);
    localparam int SHAMT_W     = $clog2(DATA_W) + 1;
    localparam int MUL_LANE_W  = 16;
    localparam int MUL_LANES   = DATA_W / MUL_LANE_W;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MULLO = 4'd2,
        OP_MULHI = 4'd3,
        OP_MADD  = 4'd4,
        OP_CMPEQ = 4'd5,
        OP_CMPGT = 4'd6,
        OP_SHL   = 4'd7,
        OP_SHRL  = 4'd8,
        OP_SHRA  = 4'd9,
        OP_AND   = 4'd10,
        OP_ANDN  = 4'd11,
        OP_OR    = 4'd12,
        OP_XOR   = 4'd13
    } op_e;
endpackage

// File: rtl/pk_lane.sv
// One lane of width W: wrapping or clamping add/subtract, signed/equal compare,
// and lane-bounded shifts.
// Assumes that the shift count arrives split into low bits plus an "upper bits set" flag,
// and that the unused opcodes produce zero.
module pk_lane
    import pk_pkg::*;
#(
    parameter int W       = 8,
    parameter int CNT_W   = 7
) (
    input  logic [3:0]       op,
    input  logic             sat,
    input  logic             sgn,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [CNT_W-1:0] shamt,
    input  logic             shbig,
    output logic [W-1:0]     r
);
    localparam logic [W-1:0]   S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]   S_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [CNT_W:0] W_CNT = (CNT_W+1)'(W);

    logic [W:0]   sum, dif;
    logic         add_sovf, sub_sovf, over;
    logic [W-1:0] add_r, sub_r;

    // Widened sum and difference, plus the signed overflow flags.
    always_comb begin
        sum      = {1'b0, a} + {1'b0, b};
        dif      = {1'b0, a} - {1'b0, b};
        add_sovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        sub_sovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        over     = shbig || ({1'b0, shamt} >= W_CNT);
    end

    // Clamp selection for add and subtract.
    always_comb begin
        if (!sat) begin
            add_r = sum[W-1:0];
            sub_r = dif[W-1:0];
        end else if (sgn) begin
            add_r = add_sovf ? (a[W-1] ? S_MIN : S_MAX) : sum[W-1:0];
            sub_r = sub_sovf ? (a[W-1] ? S_MIN : S_MAX) : dif[W-1:0];
        end else begin
            add_r = sum[W] ? {W{1'b1}} : sum[W-1:0];
            sub_r = dif[W] ? {W{1'b0}} : dif[W-1:0];
        end
    end

    // Per-lane result select.
    always_comb begin
        case (op_e'(op))
            OP_ADD:   r = add_r;
            OP_SUB:   r = sub_r;
            OP_CMPEQ: r = (a == b) ? {W{1'b1}} : {W{1'b0}};
            OP_CMPGT: r = ($signed(a) > $signed(b)) ? {W{1'b1}} : {W{1'b0}};
            OP_SHL:   r = over ? {W{1'b0}} : (a << shamt);
            OP_SHRL:  r = over ? {W{1'b0}} : (a >> shamt);
            OP_SHRA:  r = over ? {W{a[W-1]}} : W'($signed(a) >>> shamt);
            default:  r = {W{1'b0}};
        endcase
    end
endmodule

// File: rtl/pk_mul.sv
// Lane multiplier: LANES products of LANE_W-bit operands.
// Provides the low halves, the high halves and the pairwise sums of adjacent products.
// Assumes an even lane count; signedness applies to all products together.
module pk_mul #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                      sgn,
    input  logic [LANE_W*LANES-1:0]   a,
    input  logic [LANE_W*LANES-1:0]   b,
    output logic [LANE_W*LANES-1:0]   lo,
    output logic [LANE_W*LANES-1:0]   hi,
    output logic [LANE_W*LANES-1:0]   madd
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int PAIRS  = LANES / 2;

    logic [PROD_W-1:0] prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_prod
        logic signed [LANE_W:0]   xa, xb;
        logic signed [PROD_W-1:0] pf;
        // Extend each operand by one bit so one signed multiplier serves both modes.
        assign xa = {sgn & a[i*LANE_W+LANE_W-1], a[i*LANE_W +: LANE_W]};
        assign xb = {sgn & b[i*LANE_W+LANE_W-1], b[i*LANE_W +: LANE_W]};
        assign pf = PROD_W'(xa) * PROD_W'(xb);
        assign prod[i] = pf;
        assign lo[i*LANE_W +: LANE_W] = pf[LANE_W-1:0];
        assign hi[i*LANE_W +: LANE_W] = pf[PROD_W-1:LANE_W];
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        // Sum of two neighbouring products, modulo 2^PROD_W.
        assign madd[j*PROD_W +: PROD_W] = prod[2*j] + prod[2*j+1];
    end
endmodule

// File: rtl/pk_bitwise.sv
// Full-width bitwise logic: AND, AND-NOT (~a & b), OR, XOR.
// Any other opcode gives zero.
module pk_bitwise
    import pk_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    // Select one logic function.
    always_comb begin
        case (op_e'(op))
            OP_AND:  r = a & b;
            OP_ANDN: r = ~a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/psimd_alu.sv
// Packed SIMD execution unit with a registered result.
// One lane bank exists per lane width; lsz_i selects which bank drives the result.
// Assumes control and operands are valid on every edge outside reset.
// The reset is synchronous and active low.
module psimd_alu
    import pk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [LSZ_W-1:0]  lsz_i,
    input  logic              sat_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    logic [SHAMT_W-1:0]                shamt;
    logic                              shbig;
    logic [NUM_SIZES-1:0][DATA_W-1:0]  lane_res;
    logic [DATA_W-1:0]                 mul_lo, mul_hi, mul_madd, logic_res;
    logic [DATA_W-1:0]                 res_d;

    assign shamt = b_i[SHAMT_W-1:0];
    assign shbig = |b_i[DATA_W-1:SHAMT_W];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = MIN_LANE_W << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            pk_lane #(.W(LW), .CNT_W(SHAMT_W)) u_lane (
                .op    (op_i),
                .sat   (sat_i),
                .sgn   (sgn_i),
                .a     (a_i[l*LW +: LW]),
                .b     (b_i[l*LW +: LW]),
                .shamt (shamt),
                .shbig (shbig),
                .r     (lane_res[g][l*LW +: LW])
            );
        end
    end

    pk_mul #(.LANE_W(MUL_LANE_W), .LANES(MUL_LANES)) u_mul (
        .sgn  (sgn_i),
        .a    (a_i),
        .b    (b_i),
        .lo   (mul_lo),
        .hi   (mul_hi),
        .madd (mul_madd)
    );

    pk_bitwise #(.W(DATA_W)) u_logic (
        .op (op_i),
        .a  (a_i),
        .b  (b_i),
        .r  (logic_res)
    );

    // Pick the functional class that owns this opcode.
    always_comb begin
        case (op_e'(op_i))
            OP_ADD, OP_SUB, OP_CMPEQ, OP_CMPGT,
            OP_SHL, OP_SHRL, OP_SHRA:        res_d = lane_res[lsz_i];
            OP_MULLO:                        res_d = mul_lo;
            OP_MULHI:                        res_d = mul_hi;
            OP_MADD:                         res_d = mul_madd;
            OP_AND, OP_ANDN, OP_OR, OP_XOR:  res_d = logic_res;
            default:                         res_d = '0;
        endcase
    end

    // Result register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) res_o <= '0;
        else        res_o <= res_d;
    end
endmodule

// File: rtl/psimd_alu_chk.sv
// Property checker for psimd_alu.
// It watches only the ports and relates each result to the inputs of the cycle before.
module psimd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic [1:0]  lsz_i,
    input logic        sat_i,
    input logic        sgn_i,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic [63:0] res_o
);
    // True when every lane of width 8<<ls holds only copies of a single bit.
    function automatic logic mask_ok(input logic [63:0] r, input logic [1:0] ls);
        int   w;
        logic ok;
        w  = 8 << ls;
        ok = 1'b1;
        for (int i = 0; i < 64; i++)
            if (r[i] != r[(i / w) * w]) ok = 1'b0;
        return ok;
    endfunction

    // True when each result lane is at least as large as both source lanes.
    function automatic logic usat_ok(input logic [63:0] r, input logic [63:0] a,
                                     input logic [63:0] b, input logic [1:0] ls);
        int          w;
        logic [63:0] m, lr, la, lb;
        logic        ok;
        w  = 8 << ls;
        m  = (ls == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
        ok = 1'b1;
        for (int l = 0; l < 8; l++) begin
            if (l * w < 64) begin
                lr = (r >> (l * w)) & m;
                la = (a >> (l * w)) & m;
                lb = (b >> (l * w)) & m;
                if (lr < la || lr < lb) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    assert_cmp_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 || op_i == 4'd6) |=> mask_ok(res_o, $past(lsz_i)));

    assert_eq_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 && a_i == b_i) |=> (res_o == '1));

    assert_xor_self_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd13 && a_i == b_i) |=> (res_o == '0));

    assert_usat_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && sat_i && !sgn_i) |=> usat_ok(res_o, $past(a_i), $past(b_i), $past(lsz_i)));

    assert_shift_over_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 4'd7 || op_i == 4'd8) && b_i >= 64'd64) |=> (res_o == '0));

    assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd13) |=> (res_o == '0));
endmodule

bind psimd_alu psimd_alu_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .lsz_i (lsz_i),
    .sat_i (sat_i),
    .sgn_i (sgn_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (res_o)
);

// File: tb/psimd_alu_test.sv
`timescale 1ns/1ps
module psimd_alu_test;
    import pk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic [1:0]  lsz;
    logic        sat, sgn;
    logic [63:0] a, b, res;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    psimd_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .lsz_i(lsz), .sat_i(sat),
        .sgn_i(sgn), .a_i(a), .b_i(b), .res_o(res)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  lsz;
        logic        sat;
        logic        sgn;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        // R3 byte add, wrap, no carry between lanes
        '{OP_ADD, 2'd0, 1'b0, 1'b0, 64'h00FF_7F80_1234_5678, 64'h0001_0180_0101_0101, 64'h0000_8000_1335_5779, 8'd3},
        // R4 byte add, signed clamp
        '{OP_ADD, 2'd0, 1'b1, 1'b1, 64'h00FF_7F80_1234_5678, 64'h0001_0180_0101_0101, 64'h0000_7F80_1335_5779, 8'd4},
        // R5 byte add, unsigned clamp
        '{OP_ADD, 2'd0, 1'b1, 1'b0, 64'h00FF_7F80_1234_5678, 64'h0001_0180_0101_0101, 64'h00FF_80FF_1335_5779, 8'd5},
        // R5 halfword subtract, unsigned clamp to zero
        '{OP_SUB, 2'd1, 1'b1, 1'b0, 64'h0005_1000_8000_FFFF, 64'h0006_0001_0001_FFFF, 64'h0000_0FFF_7FFF_0000, 8'd5},
        // R4 halfword subtract, signed clamp
        '{OP_SUB, 2'd1, 1'b1, 1'b1, 64'h0005_1000_8000_FFFF, 64'h0006_0001_0001_FFFF, 64'hFFFF_0FFF_8000_0000, 8'd4},
        // R3 word subtract, borrow stays in lane
        '{OP_SUB, 2'd2, 1'b0, 1'b0, 64'h0, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
        // R3 single 64-bit lane wraps
        '{OP_ADD, 2'd3, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 8'd3},
        // R6 byte compare-equal
        '{OP_CMPEQ, 2'd0, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 8'd6},
        // R6 halfword signed compare-greater
        '{OP_CMPGT, 2'd1, 1'b0, 1'b0, 64'h0005_FFFF_8000_7FFF, 64'h0003_0001_7FFF_8000, 64'hFFFF_0000_0000_FFFF, 8'd6},
        // R7 multiply low halves, signed, lsz ignored
        '{OP_MULLO, 2'd0, 1'b0, 1'b1, 64'h0003_FFFF_0100_1234, 64'h0004_0002_0100_0010, 64'h000C_FFFE_0000_2340, 8'd7},
        // R7 multiply high halves, signed
        '{OP_MULHI, 2'd0, 1'b0, 1'b1, 64'h0003_FFFF_0100_1234, 64'h0004_0002_0100_0010, 64'h0000_FFFF_0001_0001, 8'd7},
        // R7 multiply high halves, unsigned
        '{OP_MULHI, 2'd2, 1'b0, 1'b0, 64'h0003_FFFF_0100_1234, 64'h0004_0002_0100_0010, 64'h0000_0001_0001_0001, 8'd7},
        // R8 multiply-add of neighbouring products
        '{OP_MADD, 2'd1, 1'b0, 1'b1, 64'h0003_FFFF_0100_1234, 64'h0004_0002_0100_0010, 64'h0000_000A_0002_2340, 8'd8},
        // R9 halfword shift left by 4
        '{OP_SHL, 2'd1, 1'b0, 1'b0, 64'h1234_8001_FFFF_000F, 64'd4, 64'h2340_0010_FFF0_00F0, 8'd9},
        // R9 word logical right by 8
        '{OP_SHRL, 2'd2, 1'b0, 1'b0, 64'h8000_0000_1234_5678, 64'd8, 64'h0080_0000_0012_3456, 8'd9},
        // R9 halfword arithmetic right by 4
        '{OP_SHRA, 2'd1, 1'b0, 1'b0, 64'h8000_7FF0_FFFF_1234, 64'd4, 64'hF800_07FF_FFFF_0123, 8'd9},
        // R10 word arithmetic right by 40 gives sign fill
        '{OP_SHRA, 2'd2, 1'b0, 1'b0, 64'h8000_0000_7FFF_FFFF, 64'd40, 64'hFFFF_FFFF_0000_0000, 8'd10},
        // R10 halfword logical right by exactly 16
        '{OP_SHRL, 2'd1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 64'h0, 8'd10},
        // R9 64-bit lane shift left by 63
        '{OP_SHL, 2'd3, 1'b0, 1'b0, 64'h1, 64'd63, 64'h8000_0000_0000_0000, 8'd9},
        // R10 count taken from all of b: upper bits set
        '{OP_SHL, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0002, 64'h0, 8'd10},
        // R11 AND-NOT, lane size and modes ignored
        '{OP_ANDN, 2'd1, 1'b1, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0000_0F0F_0000, 8'd11},
        // R11 AND
        '{OP_AND, 2'd0, 1'b1, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000, 64'hF0F0_0000_F0F0_0000, 8'd11},
        // R11 OR
        '{OP_OR, 2'd2, 1'b0, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0000_0000_0001, 64'hFFFF_F0F0_F0F0_F0F1, 8'd11},
        // R11 XOR
        '{OP_XOR, 2'd0, 1'b1, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_FFFF_0000_0000, 64'h0F0F_0F0F_F0F0_F0F0, 8'd11},
        // R12 unused opcode 15
        '{4'd15, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 8'd12},
        // R4 word add, signed clamp both directions
        '{OP_ADD, 2'd2, 1'b1, 1'b1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 8'd4}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [1:0] l, input logic s,
                         input logic g, input logic [63:0] x, input logic [63:0] y);
        op = o; lsz = l; sat = s; sgn = g; a = x; b = y;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(OP_XOR, 2'd0, 1'b0, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'h0);
        repeat (3) @(negedge clk);
        chk("R1 held in reset", res, 64'h0);
        rst_n = 1'b1;

        // Back-to-back walk: result of vector i-1 is checked as vector i is issued.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) chk($sformatf("R%0d vector %0d", VT[i-1].req, i-1), res, VT[i-1].e);
            drive(VT[i].op, VT[i].lsz, VT[i].sat, VT[i].sgn, VT[i].a, VT[i].b);
        end
        @(negedge clk);
        chk($sformatf("R%0d vector %0d", VT[NV-1].req, NV-1), res, VT[NV-1].e);

        // R2: the output holds until the edge, then takes the new result.
        drive(OP_ADD, 2'd3, 1'b0, 1'b0, 64'd1, 64'd1);
        #1;
        chk("R2 holds before edge", res, VT[NV-1].e);
        @(negedge clk);
        chk("R2 after edge", res, 64'd2);

        // R1: reset on top of a pending non-zero result.
        drive(OP_XOR, 2'd0, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0);
        @(negedge clk);
        chk("R1 pre-reset value", res, 64'h1234_5678_9ABC_DEF0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 cleared by reset", res, 64'h0);
        rst_n = 1'b1;

        // R3: byte subtract wraps 0-1 in one lane without touching its neighbour.
        drive(OP_SUB, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001);
        @(negedge clk);
        chk("R3 borrow contained", res, 64'h0000_0000_0000_01FF);

        // R12: opcode 14 is unused.
        drive(4'd14, 2'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        chk("R12 opcode 14", res, 64'h0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule